// File: doc/BRIEF.md
# Vector Coprocessor Instruction Dispatcher

This block receives coprocessor-2 instructions from a host CPU, one at a time, over a valid/ready handshake, and settles each one in a single accepted cycle. Branch-on-busy instructions become a taken/not-taken decision with a target address and a delay-slot nullify flag. Control-register and quad-register moves become one 32-bit access on a simple register bus. A read result is sign-extended and written back to the host's general register. Anything the block does not recognise becomes an exception with a cause code.

Live status from the vector unit steers the work. Branches test whether the unit is busy. Moves are held at the handshake until the unit allows them. When the unit is busy in macro mode, a move waits on a per-register hazard input. When it is busy in micro mode, a move waits only if it asks for interlock: a read waits for the unit to go idle, and a write waits for an interlock-release input.

Top module: `vcop_dispatch`

## Requirements
- R1: When `cu2_en` is low, an accepted instruction gives one `exc_valid` pulse with `exc_cause` = 1 (unusable). It produces no branch, bus or register-write output and is never stalled.
- R2: Fields are taken from `in_word`: format [25:21], condition/rt [20:16], register id [15:11], immediate [15:0], mid bits [10:1], interlock bit [0]. Format 0x08 with condition 0/1/2/3 is branch-if-not-busy, branch-if-busy, not-busy-likely and busy-likely. Busy means `vu_busy_macro` or `vu_busy_micro`.
- R3: `br_target` equals `in_pc` + 4 + (sign-extended immediate << 2).
- R4: `br_nullify` is high only for an untaken likely branch (condition 2 or 3). It is never high for conditions 0 or 1.
- R5: Format 0x02 with mid bits zero is a control read and format 0x01 is a quad read. Format 0x06 with mid bits zero is a control write and format 0x05 is a quad write. `bus_addr` = `CTRL_BASE` + id*16 for control moves and `WIN_BASE` + id*16 for quad moves.
- R6: A read drives `bus_rd`, `gpr_we` and `gpr_idx` = rt in the same cycle, with `gpr_wdata` = `bus_rdata` sign-extended to 64 bits.
- R7: A write drives `bus_wr` with `bus_wdata` = `in_rt_lo`.
- R8: With `vu_busy_macro` high, a move is held (`in_ready` low) while `vu_hazard[id]` is high. The interlock bit has no effect.
- R9: With only `vu_busy_micro` high, a move with the interlock bit clear is not held. With the bit set, a read is held while `vu_busy_micro` is high, and a write is held while `vu_ilock_rel` is low.
- R10: Any other encoding (including a move format whose mid bits are nonzero, and format 0x08 with condition above 3) gives one `exc_valid` pulse with `exc_cause` = 2 (reserved) and nothing else.
- R11: Each accepted instruction produces exactly one of `br_valid`, `bus_rd`, `bus_wr`, `exc_valid`, one cycle after acceptance and for one cycle. Every output strobe is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction accepted this cycle when high with `in_valid` |
| in_word | input | 26 | Coprocessor field of the instruction (bits 25:0) |
| in_pc | input | AW | Address of the instruction |
| in_rt_lo | input | 32 | Low 32 bits of general register rt |
| cu2_en | input | 1 | Coprocessor-2 usable bit of the status register |
| vu_busy_macro | input | 1 | Vector unit busy in macro mode |
| vu_busy_micro | input | 1 | Vector unit busy in micro mode |
| vu_hazard | input | 32 | Per-register-id hazard flags in macro mode |
| vu_ilock_rel | input | 1 | Micro-mode interlock released |
| br_valid | output | 1 | Branch resolved |
| br_taken | output | 1 | Branch taken |
| br_target | output | AW | Branch target address |
| br_nullify | output | 1 | Nullify the delay-slot instruction |
| bus_rd | output | 1 | Register-bus read strobe |
| bus_wr | output | 1 | Register-bus write strobe |
| bus_addr | output | AW | Register-bus address |
| bus_wdata | output | 32 | Register-bus write data |
| bus_rdata | input | 32 | Register-bus read data, valid in the `bus_rd` cycle |
| gpr_we | output | 1 | General-register write enable |
| gpr_idx | output | 5 | General-register index |
| gpr_wdata | output | 64 | General-register write data |
| exc_valid | output | 1 | Exception pulse |
| exc_cause | output | 2 | 1 = coprocessor unusable, 2 = reserved instruction |

## Verification
Every cycle, the assertions check that the outputs of an accepted instruction are mutually exclusive and appear one cycle after acceptance. They also check that a read always pairs its bus strobe with a sign-extended register write, that nullify never accompanies a taken branch, and that the macro-hazard and micro-interlock conditions hold `in_ready` low. Only the bench's scenarios can show the numeric parts and the stall release: correct target arithmetic for negative offsets, the taken decision for each of the four conditions under each busy state, the control and quad base addresses, and that a held move proceeds with the right address once its hazard clears or the interlock is released.

// File: rtl/vcop_dispatch.sv
module vcop_dispatch #(
  parameter int AW = 32,
  parameter logic [AW-1:0] CTRL_BASE = AW'(32'h1000_3800),
  parameter logic [AW-1:0] WIN_BASE  = AW'(32'h1100_4000)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [25:0]   in_word,
  input  logic [AW-1:0] in_pc,
  input  logic [31:0]   in_rt_lo,
  input  logic          cu2_en,
  input  logic          vu_busy_macro,
  input  logic          vu_busy_micro,
  input  logic [31:0]   vu_hazard,
  input  logic          vu_ilock_rel,
  output logic          br_valid,
  output logic          br_taken,
  output logic [AW-1:0] br_target,
  output logic          br_nullify,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic [AW-1:0] bus_addr,
  output logic [31:0]   bus_wdata,
  input  logic [31:0]   bus_rdata,
  output logic          gpr_we,
  output logic [4:0]    gpr_idx,
  output logic [63:0]   gpr_wdata,
  output logic          exc_valid,
  output logic [1:0]    exc_cause
);
  localparam logic [1:0] CAUSE_UNUSABLE = 2'd1;
  localparam logic [1:0] CAUSE_RESERVED = 2'd2;

  logic [4:0] fmt, cnd, rid;
  logic       ilk, mid_zero;
  assign fmt      = in_word[25:21];
  assign cnd      = in_word[20:16];
  assign rid      = in_word[15:11];
  assign ilk      = in_word[0];
  assign mid_zero = (in_word[10:1] == 10'd0);

  logic is_br, is_rd, is_wr, is_quad, is_move, busy;
  assign is_br   = (fmt == 5'h08) && (cnd[4:2] == 3'd0);
  assign is_rd   = (fmt == 5'h01) || (fmt == 5'h02 && mid_zero);
  assign is_wr   = (fmt == 5'h05) || (fmt == 5'h06 && mid_zero);
  assign is_quad = (fmt == 5'h01) || (fmt == 5'h05);
  assign is_move = is_rd || is_wr;
  assign busy    = vu_busy_macro || vu_busy_micro;

  logic hold;
  always_comb begin
    hold = 1'b0;
    if (cu2_en && is_move) begin
      if (vu_busy_macro)
        hold = vu_hazard[rid];
      else if (vu_busy_micro && ilk)
        hold = is_rd ? 1'b1 : !vu_ilock_rel;
    end
  end

  logic fire, taken;
  logic [AW-1:0] tgt, addr;
  assign in_ready = !hold;
  assign fire     = in_valid && in_ready;
  assign taken    = cnd[0] ? busy : !busy;
  assign tgt      = in_pc + AW'(4) + AW'({{(AW-16){in_word[15]}}, in_word[15:0]} << 2);
  assign addr     = (is_quad ? WIN_BASE : CTRL_BASE) + AW'({rid, 4'b0000});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      br_valid   <= 1'b0;
      br_taken   <= 1'b0;
      br_nullify <= 1'b0;
      br_target  <= '0;
      bus_rd     <= 1'b0;
      bus_wr     <= 1'b0;
      bus_addr   <= '0;
      bus_wdata  <= '0;
      gpr_idx    <= '0;
      exc_valid  <= 1'b0;
      exc_cause  <= '0;
    end else begin
      br_valid  <= fire && cu2_en && is_br;
      bus_rd    <= fire && cu2_en && is_rd;
      bus_wr    <= fire && cu2_en && is_wr;
      exc_valid <= fire && !(cu2_en && (is_br || is_move));
      if (fire) begin
        br_taken   <= taken;
        br_nullify <= cnd[1] && !taken;
        br_target  <= tgt;
        bus_addr   <= addr;
        bus_wdata  <= in_rt_lo;
        gpr_idx    <= cnd;
        exc_cause  <= cu2_en ? CAUSE_RESERVED : CAUSE_UNUSABLE;
      end
    end
  end

  assign gpr_we    = bus_rd;
  assign gpr_wdata = {{32{bus_rdata[31]}}, bus_rdata};

  p_unusable_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cu2_en) |=> (exc_valid && exc_cause == CAUSE_UNUSABLE && !br_valid && !bus_rd && !bus_wr));
  p_unusable_no_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cu2_en) |-> in_ready);
  p_nullify_untaken_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_nullify) |-> !br_taken);
  p_read_writeback_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |-> (gpr_we && gpr_wdata[63:32] == {32{gpr_wdata[31]}}));
  p_macro_hazard_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cu2_en && vu_busy_macro && vu_hazard[in_word[15:11]] &&
     (in_word[25:21] == 5'h01 || in_word[25:21] == 5'h05)) |-> !in_ready);
  p_micro_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cu2_en && !vu_busy_macro && vu_busy_micro && in_word[0] &&
     in_word[25:21] == 5'h01) |-> !in_ready);
  p_micro_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !vu_busy_macro && !in_word[0]) |-> in_ready);
  p_one_action_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({br_valid, bus_rd, bus_wr, exc_valid}));
  p_accept_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (br_valid || bus_rd || bus_wr || exc_valid));
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> !(br_valid || bus_rd || bus_wr || exc_valid));
endmodule

// File: tb/vcop_dispatch_tb_top.sv
module vcop_dispatch_tb_top;
  localparam logic [31:0] CB = 32'h1000_3800;
  localparam logic [31:0] WB = 32'h1100_4000;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        in_valid = 0, cu2_en = 0, bmac = 0, bmic = 0, rel = 0;
  logic [25:0] in_word = '0;
  logic [31:0] in_pc = '0, in_rt_lo = '0, hz = '0;
  logic        in_ready, br_valid, br_taken, br_nullify, bus_rd, bus_wr, gpr_we, exc_valid;
  logic [31:0] br_target, bus_addr, bus_wdata, bus_rdata;
  logic [4:0]  gpr_idx;
  logic [63:0] gpr_wdata;
  logic [1:0]  exc_cause;

  assign bus_rdata = bus_addr ^ {bus_addr[8:4], 27'h0123456};

  vcop_dispatch dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_pc(in_pc), .in_rt_lo(in_rt_lo), .cu2_en(cu2_en),
    .vu_busy_macro(bmac), .vu_busy_micro(bmic), .vu_hazard(hz), .vu_ilock_rel(rel),
    .br_valid(br_valid), .br_taken(br_taken), .br_target(br_target), .br_nullify(br_nullify),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .gpr_we(gpr_we), .gpr_idx(gpr_idx), .gpr_wdata(gpr_wdata),
    .exc_valid(exc_valid), .exc_cause(exc_cause));

  int vectors = 0, miscompares = 0;

  typedef struct {
    bit br, rd, wr, ex, tk, nul;
    bit [31:0] tgt, addr, wd;
    bit [4:0] idx;
    bit [1:0] cause;
    string req;
  } exp_t;
  exp_t e;

  function automatic bit [25:0] mk(bit [4:0] f, bit [4:0] r, bit [4:0] id, bit [10:0] lo);
    return {f, r, id, lo};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(bit v, bit [25:0] w, bit [31:0] pc, bit [31:0] rtv, bit cu,
                      bit mac, bit mic, bit [31:0] h, bit rl, string req);
    bit [4:0] f, c, id;
    bit move, rdop, wrop, quad, busy, stall, acc;
    in_valid = v; in_word = w; in_pc = pc; in_rt_lo = rtv; cu2_en = cu;
    bmac = mac; bmic = mic; hz = h; rel = rl;
    #1;
    f = w[25:21]; c = w[20:16]; id = w[15:11];
    rdop = (f == 5'd1) || (f == 5'd2 && w[10:1] == 0);
    wrop = (f == 5'd5) || (f == 5'd6 && w[10:1] == 0);
    quad = (f == 5'd1) || (f == 5'd5);
    move = rdop || wrop;
    busy = mac || mic;
    stall = 0;
    if (cu && move) begin
      if (mac) stall = h[id];
      else if (mic && w[0]) stall = rdop ? 1'b1 : !rl;
    end
    chk(in_ready === !stall, req, "in_ready", in_ready, !stall);
    acc = v && !stall;
    e = '{default: 0, req: req};
    if (acc) begin
      if (!cu) begin e.ex = 1; e.cause = 1; end
      else if (f == 5'd8 && c < 4) begin
        e.br = 1;
        e.tk = c[0] ? busy : !busy;
        e.nul = c[1] && !e.tk;
        e.tgt = pc + 4 + ($signed({{16{w[15]}}, w[15:0]}) * 4);
      end else if (move) begin
        e.rd = rdop; e.wr = wrop;
        e.addr = (quad ? WB : CB) + id * 16;
        e.wd = rtv; e.idx = c;
      end else begin e.ex = 1; e.cause = 2; end
    end
    @(negedge clk); #1;
    chk(br_valid === e.br && bus_rd === e.rd && bus_wr === e.wr && exc_valid === e.ex && gpr_we === e.rd,
        e.req, "strobes", {br_valid, bus_rd, bus_wr, exc_valid, gpr_we}, {e.br, e.rd, e.wr, e.ex, e.rd});
    if (e.br) chk(br_taken === e.tk && br_nullify === e.nul && br_target === e.tgt, e.req, "branch",
                  {br_taken, br_nullify, br_target}, {e.tk, e.nul, e.tgt});
    if (e.rd || e.wr) chk(bus_addr === e.addr, e.req, "bus_addr", bus_addr, e.addr);
    if (e.wr) chk(bus_wdata === e.wd, e.req, "bus_wdata", bus_wdata, e.wd);
    if (e.rd) begin
      bit [31:0] rv;
      rv = e.addr ^ {e.addr[8:4], 27'h0123456};
      chk(gpr_idx === e.idx && gpr_wdata === {{32{rv[31]}}, rv}, e.req, "gpr",
          gpr_wdata, {{32{rv[31]}}, rv});
    end
    if (e.ex) chk(exc_cause === e.cause, e.req, "exc_cause", exc_cause, e.cause);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R11: reset state
    chk(!br_valid && !bus_rd && !bus_wr && !exc_valid && in_ready, "R11", "reset", 0, 0);
    rst_n = 1;
    @(negedge clk); #1;

    // R1: unusable, not held even with hazards set
    step(1, mk(5'h01, 5'd3, 5'd4, 11'd0), 32'h100, 0, 0, 1, 0, 32'hFFFF_FFFF, 0, "R1");
    step(1, mk(5'h08, 5'd0, 5'd0, 11'd8), 32'h100, 0, 0, 0, 0, 0, 0, "R1");

    // R2 R3 R4: all branch conditions under idle and busy
    for (int c = 0; c < 4; c++) begin
      step(1, {5'h08, 5'(c), 16'h0010}, 32'h2000, 0, 1, 0, 0, 0, 0, "R2");
      step(1, {5'h08, 5'(c), 16'hFFF0}, 32'h2000, 0, 1, 1, 0, 0, 0, "R4");
      step(1, {5'h08, 5'(c), 16'h8000}, 32'h8000_0000, 0, 1, 0, 1, 0, 0, "R3");
    end

    // R5 R6: control and quad reads, both sign polarities
    step(1, mk(5'h02, 5'd7, 5'd3, 11'd0), 0, 0, 1, 0, 0, 0, 0, "R5");
    step(1, mk(5'h02, 5'd9, 5'd20, 11'd0), 0, 0, 1, 0, 0, 0, 0, "R6");
    step(1, mk(5'h01, 5'd31, 5'd31, 11'h7FE), 0, 0, 1, 0, 0, 0, 0, "R5");
    step(1, mk(5'h01, 5'd2, 5'd0, 11'd0), 0, 0, 1, 0, 0, 0, 0, "R6");
    // R7: control and quad writes
    step(1, mk(5'h06, 5'd5, 5'd12, 11'd0), 0, 32'hDEAD_BEEF, 1, 0, 0, 0, 0, "R7");
    step(1, mk(5'h05, 5'd6, 5'd17, 11'd1), 0, 32'h1234_5678, 1, 0, 0, 0, 0, "R7");

    // R8: macro hazard holds the move; interlock bit ignored; other id no hold
    for (int k = 0; k < 3; k++)
      step(1, mk(5'h01, 5'd1, 5'd9, 11'd1), 0, 0, 1, 1, 1, 32'h0000_0200, 1, "R8");
    step(1, mk(5'h01, 5'd1, 5'd9, 11'd1), 0, 0, 1, 1, 1, 32'h0000_0000, 1, "R8");
    step(1, mk(5'h06, 5'd1, 5'd9, 11'd0), 0, 32'h55, 1, 1, 0, 32'hFFFF_FDFF, 0, "R8");
    step(1, mk(5'h05, 5'd1, 5'd2, 11'd1), 0, 32'h77, 1, 1, 0, 32'h0000_0004, 0, "R8");
    step(1, mk(5'h05, 5'd1, 5'd2, 11'd1), 0, 32'h77, 1, 1, 0, 32'h0000_0000, 0, "R8");

    // R9: micro mode
    step(1, mk(5'h02, 5'd4, 5'd1, 11'd0), 0, 0, 1, 0, 1, 0, 0, "R9");
    for (int k = 0; k < 2; k++)
      step(1, mk(5'h01, 5'd4, 5'd1, 11'd1), 0, 0, 1, 0, 1, 0, 1, "R9");
    step(1, mk(5'h01, 5'd4, 5'd1, 11'd1), 0, 0, 1, 0, 0, 0, 0, "R9");
    for (int k = 0; k < 2; k++)
      step(1, mk(5'h05, 5'd4, 5'd8, 11'd1), 0, 32'hAB, 1, 0, 1, 0, 0, "R9");
    step(1, mk(5'h05, 5'd4, 5'd8, 11'd1), 0, 32'hAB, 1, 0, 1, 0, 1, "R9");

    // R10: reserved encodings
    step(1, mk(5'h02, 5'd1, 5'd1, 11'd2), 0, 0, 1, 0, 0, 0, 0, "R10");
    step(1, mk(5'h06, 5'd1, 5'd1, 11'h400), 0, 0, 1, 0, 0, 0, 0, "R10");
    step(1, mk(5'h08, 5'd4, 5'd0, 11'd0), 0, 0, 1, 0, 0, 0, 0, "R10");
    step(1, mk(5'h10, 5'd0, 5'd0, 11'd0), 0, 0, 1, 0, 0, 0, 0, "R10");

    // R11: idle cycles give no output
    step(0, mk(5'h01, 5'd1, 5'd1, 11'd0), 0, 0, 1, 0, 0, 0, 0, "R11");
    step(0, mk(5'h10, 5'd1, 5'd1, 11'd0), 0, 0, 0, 0, 0, 0, 0, "R11");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule